// File: doc/BRIEF.md
# Two-Bank Frame Context Switch

This block keeps two complete banks of sensor timing and gain settings, bank A and bank B, and tells the readout timing logic which values apply to the current frame. A single select input names the bank that should be in use. A one-cycle frame-start strobe marks each frame boundary, and the effective values are captured into frame-stable output registers only on that strobe. Writes to either bank, and changes of the select input, therefore never disturb a frame that is already running.

Exposure has to lead readout by one frame. When the select input names a different bank at a frame start, only the integration-time slot (register index 0) takes its value from the new bank at that strobe. All other slots follow at the next strobe. Between those two strobes the switch is pending: the select input is ignored, and a further request waits until the first switch has finished. With the default of eight slots, index 0 is integration time. The other slots carry line length, frame length, binning control, analog gain, digital gain, window start and window end, at indices 1 to 7. The block gives no meaning to those values.

Top module: `ctxsw_top`

## Requirements
- R1: After reset both status outputs read context A (0), and every effective slot and every bank entry reads zero.
- R2: A write with `wr_bank` 0 (A) or 1 (B) and slot `wr_idx` stores `wr_data` into that bank. It reaches `eff_regs` at the first frame strobe whose selected context for that slot is that bank.
- R3: `ctx_sel` is sampled only in a cycle where `frame_start` is 1. Toggling it between strobes has no effect; only its value at the strobe counts.
- R4: When no switch is pending and `ctx_sel` at a strobe differs from the exposure context, a switch from A to B begins. At that strobe slot 0 loads from bank B, and slots 1 and above reload from the old bank.
- R5: At the next strobe after a switch began, slots 1 and above load from the new bank, and the readout context equals the exposure context.
- R6: A switch from B back to A follows the same two-stage timing as R4 and R5.
- R7: While a switch is pending, `ctx_sel` at a strobe is ignored. A different request is taken at the strobe after the pending switch has completed.
- R8: Writes to a bank that is not in use leave `eff_regs` and the status outputs unchanged.
- R9: Between strobes `eff_regs` stays constant, even when the bank in use is written.
- R10: `exp_ctx` reports the context used by slot 0, and `rd_ctx` reports the context used by all other slots (0 = A, 1 = B). Both update one cycle after a strobe.
- R11: A write issued in the same cycle as a strobe is stored in the bank. It is not captured by that strobe, and it applies from a later strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Bank write strobe |
| wr_bank | input | 1 | Target bank of the write: 0 = A, 1 = B |
| wr_idx | input | IDX_W (3) | Slot index of the write; 0 is integration time |
| wr_data | input | DATA_W (16) | Write data |
| ctx_sel | input | 1 | Requested context: 0 = A, 1 = B |
| frame_start | input | 1 | One-cycle frame boundary strobe |
| eff_regs | output | NREG*DATA_W (128) | Effective values; slot k at bits [k*DATA_W +: DATA_W] |
| exp_ctx | output | 1 | Context used by the integration-time slot |
| rd_ctx | output | 1 | Context used by all other slots |

## Verification
The assertions assume that `frame_start`, `ctx_sel` and the write inputs are synchronous to `clk` and hold known values once reset has been released. They place no limit on how often strobes arrive. The stimulus drives every input on the falling edge, issues each strobe and each write as a single-cycle pulse, and toggles `ctx_sel` only between strobes. The exception is the deliberate case of a write in the same cycle as a strobe. An 8-bit select pattern is swept across eight frames per pattern, so every sequence of requests, pending switches and ignored requests occurs.

// File: rtl/ctxsw_pkg.sv
package ctxsw_pkg;
  typedef enum logic {
    CTX_A = 1'b0,
    CTX_B = 1'b1
  } ctx_e;
endpackage

// File: rtl/ctxsw_bank.sv
module ctxsw_bank #(
  parameter int DATA_W  = 16,
  parameter int NREG    = 8,
  parameter int IDX_W   = 3,
  parameter bit BANK_ID = 1'b0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic                   wr_bank,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic [DATA_W-1:0]      wr_data,
  output logic [NREG*DATA_W-1:0] regs_q
);
  logic bank_hit;
  assign bank_hit = wr_en && (wr_bank == BANK_ID);

  for (genvar i = 0; i < NREG; i++) begin : g_slot
    logic slot_en;
    assign slot_en = bank_hit && (wr_idx == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs_q[i*DATA_W +: DATA_W] <= '0;
      end else if (slot_en) begin
        regs_q[i*DATA_W +: DATA_W] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/ctxsw_seq.sv
module ctxsw_seq
  import ctxsw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic frame_start,
  input  logic ctx_sel,
  output ctx_e exp_q,
  output ctx_e rd_q,
  output ctx_e exp_d,
  output ctx_e rd_d
);
  logic pending;
  assign pending = (exp_q != rd_q);

  always_comb begin
    exp_d = exp_q;
    rd_d  = rd_q;
    if (frame_start) begin
      if (pending) begin
        rd_d = exp_q;
      end else begin
        exp_d = ctx_e'(ctx_sel);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q <= CTX_A;
      rd_q  <= CTX_A;
    end else if (frame_start) begin
      exp_q <= exp_d;
      rd_q  <= rd_d;
    end
  end
endmodule

// File: rtl/ctxsw_shadow.sv
module ctxsw_shadow
  import ctxsw_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int NREG   = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   frame_start,
  input  ctx_e                   exp_d,
  input  ctx_e                   rd_d,
  input  logic [NREG*DATA_W-1:0] bank_a,
  input  logic [NREG*DATA_W-1:0] bank_b,
  output logic [NREG*DATA_W-1:0] eff_q
);
  logic [NREG*DATA_W-1:0] eff_d;

  for (genvar i = 0; i < NREG; i++) begin : g_mux
    ctx_e src;
    if (i == 0) begin : g_exposure
      assign src = exp_d;
    end else begin : g_readout
      assign src = rd_d;
    end
    assign eff_d[i*DATA_W +: DATA_W] = (src == CTX_B) ? bank_b[i*DATA_W +: DATA_W]
                                                      : bank_a[i*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eff_q <= '0;
    end else if (frame_start) begin
      eff_q <= eff_d;
    end
  end
endmodule

// File: rtl/ctxsw_top.sv
module ctxsw_top
  import ctxsw_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int NREG   = 8,
  localparam int IDX_W = $clog2(NREG),
  localparam int FLAT_W = NREG * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_bank,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ctx_sel,
  input  logic              frame_start,
  output logic [FLAT_W-1:0] eff_regs,
  output logic              exp_ctx,
  output logic              rd_ctx
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  logic [FLAT_W-1:0] bank_q [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    ctxsw_bank #(
      .DATA_W (DATA_W),
      .NREG   (NREG),
      .IDX_W  (IDX_W),
      .BANK_ID(1'(b))
    ) u_bank (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .wr_en  (wr_en),
      .wr_bank(wr_bank),
      .wr_idx (wr_idx),
      .wr_data(wr_data),
      .regs_q (bank_q[b])
    );
  end

  ctx_e exp_q, rd_q, exp_d, rd_d;

  ctxsw_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .frame_start(frame_start),
    .ctx_sel    (ctx_sel),
    .exp_q      (exp_q),
    .rd_q       (rd_q),
    .exp_d      (exp_d),
    .rd_d       (rd_d)
  );

  ctxsw_shadow #(
    .DATA_W(DATA_W),
    .NREG  (NREG)
  ) u_shadow (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .frame_start(frame_start),
    .exp_d      (exp_d),
    .rd_d       (rd_d),
    .bank_a     (bank_q[0]),
    .bank_b     (bank_q[1]),
    .eff_q      (eff_regs)
  );

  assign exp_ctx = exp_q;
  assign rd_ctx  = rd_q;
endmodule

// File: rtl/ctxsw_chk.sv
module ctxsw_chk #(
  parameter int FLAT_W = 128
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              frame_start,
  input logic              ctx_sel,
  input logic [FLAT_W-1:0] eff_regs,
  input logic              exp_ctx,
  input logic              rd_ctx
);
  p_hold_between_frames_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !frame_start |=> ($stable(eff_regs) && $stable(exp_ctx) && $stable(rd_ctx)));

  p_finish_pending_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (frame_start && (exp_ctx != rd_ctx)) |=> ((rd_ctx == $past(exp_ctx)) && $stable(exp_ctx)));

  p_sample_select_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (frame_start && (exp_ctx == rd_ctx)) |=> ((exp_ctx == $past(ctx_sel)) && $stable(rd_ctx)));

  p_readout_trails_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !$stable(rd_ctx) |-> (rd_ctx == exp_ctx));

  p_exposure_leads_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !$stable(exp_ctx) |-> (rd_ctx == $past(rd_ctx)));
endmodule

bind ctxsw_top ctxsw_chk #(.FLAT_W(FLAT_W)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .frame_start(frame_start),
  .ctx_sel    (ctx_sel),
  .eff_regs   (eff_regs),
  .exp_ctx    (exp_ctx),
  .rd_ctx     (rd_ctx)
);

// File: tb/tb_ctxsw_top.sv
`timescale 1ns/1ps
module tb_ctxsw_top;
  localparam int DW = 16;
  localparam int NR = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en, wr_bank, ctx_sel, frame_start;
  logic [2:0]    wr_idx;
  logic [DW-1:0] wr_data;
  logic [NR*DW-1:0] eff_regs;
  logic          exp_ctx, rd_ctx;

  always #4 clk = ~clk;

  ctxsw_top #(.DATA_W(DW), .NREG(NR)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bank(wr_bank),
    .wr_idx(wr_idx), .wr_data(wr_data), .ctx_sel(ctx_sel),
    .frame_start(frame_start), .eff_regs(eff_regs),
    .exp_ctx(exp_ctx), .rd_ctx(rd_ctx)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [DW-1:0] mb [2][NR];
  logic [DW-1:0] me [NR];
  logic mx, mr;

  function automatic logic [DW-1:0] data_of(int pat, int f, int b, int k);
    return {1'(b), 3'(pat), 3'(f), 3'(pat >> 3), 6'(k)};
  endfunction

  task automatic chk(bit ok, string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    for (int k = 0; k < NR; k++)
      chk(eff_regs[k*DW +: DW] === me[k], tag, eff_regs[k*DW +: DW], me[k]);
    chk(exp_ctx === mx, "R10 exposure context", DW'(exp_ctx), DW'(mx));
    chk(rd_ctx === mr, "R10 readout context", DW'(rd_ctx), DW'(mr));
  endtask

  task automatic wr(bit b, int idx, logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1; wr_bank = b; wr_idx = 3'(idx); wr_data = d;
    @(negedge clk);
    wr_en = 0;
    mb[b][idx] = d;
  endtask

  task automatic strobe(bit ww, bit b, int idx, logic [DW-1:0] d, bit glitch);
    string tag;
    bit pend;
    pend = (mx != mr);
    if (ww) tag = "R11 coincident write";
    else if (pend && ctx_sel != mx) tag = "R7 request while pending";
    else if (pend) tag = "R5 second stage";
    else if (ctx_sel != mx) tag = ctx_sel ? "R4 switch A to B" : "R6 switch B to A";
    else if (glitch) tag = "R3 toggle between strobes";
    else tag = "R2 steady frame";
    @(negedge clk);
    frame_start = 1;
    if (ww) begin
      wr_en = 1; wr_bank = b; wr_idx = 3'(idx); wr_data = d;
    end
    if (pend) mr = mx;
    else mx = ctx_sel;
    me[0] = mb[mx][0];
    for (int k = 1; k < NR; k++) me[k] = mb[mr][k];
    if (ww) mb[b][idx] = d;
    @(negedge clk);
    frame_start = 0; wr_en = 0;
    check_all(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; wr_en = 0; wr_bank = 0; wr_idx = '0; wr_data = '0;
    ctx_sel = 0; frame_start = 0;
    mx = 0; mr = 0;
    for (int b = 0; b < 2; b++)
      for (int k = 0; k < NR; k++) mb[b][k] = '0;
    for (int k = 0; k < NR; k++) me[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check_all("R1 reset state");
    // Bank contents after reset: strobe with no writes must expose zeros.
    strobe(0, 0, 0, '0, 0);

    for (int pat = 0; pat < 256; pat++) begin
      for (int f = 0; f < 8; f++) begin
        int k;
        bit s, glitch;
        k = (pat + f) % NR;
        s = pat[f];
        glitch = f[0] ^ pat[0];
        wr(0, k, data_of(pat, f, 0, k));
        wr(1, k, data_of(pat, f, 1, k));
        wr(0, 0, data_of(pat, f, 0, 8));
        wr(1, 0, data_of(pat, f, 1, 8));
        check_all("R8 R9 writes between strobes");
        if (glitch) begin
          @(negedge clk); ctx_sel = ~s;
          @(negedge clk); ctx_sel = s;
          @(negedge clk); ctx_sel = ~s;
          check_all("R3 select toggled mid-frame");
        end
        @(negedge clk); ctx_sel = s;
        strobe(f == 3, pat[1], (pat >> 2) % NR, data_of(pat, f, 1, 9) ^ DW'(pat), glitch);
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule